// File: doc/BRIEF.md
# Nibble-Stream Frame Check Sequence Generator

This block sits on the transmit path of a 4-bit MAC datapath. It runs at one quarter of the line bit rate, which is twice the byte rate. Frame nibbles arrive one per clock and carry the destination address, source address, length/type field and payload. Each accepted nibble is forwarded to the output one cycle later. Meanwhile a 32-bit CRC register is folded forward through a parallel update that consumes all four bits in one step, and each cycle's result feeds the next cycle's update.

When the nibble flagged as end of frame has been accepted, the block turns the register into the frame check sequence (FCS) by inverting every bit and then mirroring the bit order. It sends the FCS as eight more output nibbles, directly after the last data nibble. While those eight nibbles drain, the input ready signal is low. Frames may be of any length, from a single nibble upward, and the sender may leave idle cycles inside a frame.

Top module: `nib_fcs_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and on the cycle after it is released, `out_vld` and `out_last` are 0 and `in_rdy` is 1. A reset during the FCS tail abandons the tail.
- R2: A nibble is accepted when `in_vld` and `in_rdy` are both 1. It appears on `out_dat` one clock later with `out_vld`=1 and `out_last`=0.
- R3: The CRC uses generator polynomial 0x04C11DB7. The register is preset to 0xFFFFFFFF for the nibble that carries `in_sof`. Each nibble is consumed bit 0 first, and a byte is presented low nibble first.
- R4: The FCS is the final CRC register inverted and then bit-reversed. FCS nibble k is FCS bits [4k+3:4k]. Nibbles k=0..7 appear in order on the eight cycles that follow the last data nibble's output cycle, with no gap.
- R5: `out_last` is 1 only on the eighth FCS nibble.
- R6: After an accepted `in_eof` nibble, `in_rdy` is 0 for exactly eight cycles. Anything presented during those cycles is ignored: it produces no output and leaves the CRC unchanged.
- R7: For the ASCII bytes "123456789", the FCS is 0xCBF43926, so the output nibbles are 6,2,9,3,4,F,B,C.
- R8: Frames of any length give the correct FCS. This includes a single nibble carrying both `in_sof` and `in_eof`, and frames that start on the first cycle `in_rdy` returns.
- R9: A cycle inside a frame with `in_vld`=0 produces no output and does not change the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input nibble valid |
| in_sof | input | 1 | Input nibble is the first of its frame |
| in_eof | input | 1 | Input nibble is the last of its frame |
| in_dat | input | 4 | Input nibble |
| in_rdy | output | 1 | Block can accept a nibble this cycle |
| out_vld | output | 1 | Output nibble valid |
| out_dat | output | 4 | Output nibble (frame data, then FCS) |
| out_last | output | 1 | Final FCS nibble of the frame |

## Verification
The assertions assume well-formed framing: `in_sof` is raised only on a frame's first accepted nibble, `in_eof` only on its last, and no nibble counts unless `in_rdy` is high. The stimulus respects this for every frame it intends to send. During the eight stalled cycles it deliberately drives random junk, including random start and end flags, to show that the junk is ignored. It also leaves random idle gaps inside frames and applies a reset in the middle of a tail.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [0:0] {
      ST_OPEN = 1'b0,
      ST_TAIL = 1'b1
   } fcs_state_e;

endpackage

// File: rtl/fcs_crc_step.sv
module fcs_crc_step #(
   parameter int              CRC_W  = 32,
   parameter int              DATA_W = 4,
   parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7
) (
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [CRC_W-1:0]  crc_o
);

   if (DATA_W < 1) begin : g_bad_w
      $error("fcs_crc_step: DATA_W must be at least 1");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("fcs_crc_step: generator must have its x^0 term");
   end

   logic [CRC_W-1:0] chain [DATA_W+1];

   assign chain[0] = crc_i;

   // One shift stage per data bit, bit 0 entering first.
   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      logic fb;
      assign fb           = dat_i[g] ^ chain[g][CRC_W-1];
      assign chain[g+1]   = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_o = chain[DATA_W];

endmodule

// File: rtl/fcs_crc_reg.sv
module fcs_crc_reg #(
   parameter int               CRC_W  = 32,
   parameter int               DATA_W = 4,
   parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
   parameter logic [CRC_W-1:0] INIT   = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic              first_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [CRC_W-1:0]  crc_q
);

   logic [CRC_W-1:0] seed;
   logic [CRC_W-1:0] crc_nxt;

   // The first nibble of a frame is folded into the preset, not into old state.
   assign seed = first_i ? INIT : crc_q;

   fcs_crc_step #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W),
      .POLY   (POLY)
   ) i_step (
      .crc_i (seed),
      .dat_i (dat_i),
      .crc_o (crc_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         crc_q <= INIT;
      end else if (load_en) begin
         crc_q <= crc_nxt;
      end
   end

   // R9 / R6: without a load the register must not move
   p_crc_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(crc_q))
      else $error("crc register changed without an accepted nibble");

endmodule

// File: rtl/fcs_tail.sv
module fcs_tail #(
   parameter int               CRC_W       = 32,
   parameter int               DATA_W      = 4,
   parameter logic [CRC_W-1:0] XOR_OUT     = '1,
   parameter bit               REFLECT_OUT = 1'b1,
   localparam int              N_TAIL      = CRC_W / DATA_W,
   localparam int              SEL_W       = (N_TAIL > 1) ? $clog2(N_TAIL) : 1
) (
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [DATA_W-1:0] nib_o
);

   logic [CRC_W-1:0] inv;
   logic [CRC_W-1:0] fcs;

   assign inv = crc_i ^ XOR_OUT;

   if (REFLECT_OUT) begin : g_mirror
      for (genvar i = 0; i < CRC_W; i++) begin : g_bit
         assign fcs[i] = inv[CRC_W-1-i];
      end
   end else begin : g_straight
      assign fcs = inv;
   end

   // Slice k carries the least significant unsent bits.
   assign nib_o = fcs[sel_i*DATA_W +: DATA_W];

endmodule

// File: rtl/nib_fcs_gen.sv
module nib_fcs_gen #(
   parameter int               DATA_W      = 4,
   parameter int               CRC_W       = 32,
   parameter logic [CRC_W-1:0] POLY        = 32'h04C11DB7,
   parameter logic [CRC_W-1:0] INIT        = '1,
   parameter logic [CRC_W-1:0] XOR_OUT     = '1,
   parameter bit               REFLECT_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [DATA_W-1:0] in_dat,
   output logic              in_rdy,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_dat,
   output logic              out_last
);

   import fcs_pkg::*;

   localparam int             N_TAIL   = CRC_W / DATA_W;
   localparam int             CNT_W    = (N_TAIL > 1) ? $clog2(N_TAIL) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_TAIL - 1);

   if (CRC_W % DATA_W != 0) begin : g_bad_split
      $error("nib_fcs_gen: CRC_W must be a multiple of DATA_W");
   end
   if (N_TAIL < 2) begin : g_bad_tail
      $error("nib_fcs_gen: FCS must span at least two output slices");
   end

   fcs_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic             accept;
   logic [CRC_W-1:0] crc_q;
   logic [DATA_W-1:0] tail_nib;

   assign in_rdy = (st == ST_OPEN);
   assign accept = in_vld & in_rdy;

   fcs_crc_reg #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W),
      .POLY   (POLY),
      .INIT   (INIT)
   ) i_crc (
      .clk     (clk),
      .rst     (rst),
      .load_en (accept),
      .first_i (in_sof),
      .dat_i   (in_dat),
      .crc_q   (crc_q)
   );

   fcs_tail #(
      .CRC_W       (CRC_W),
      .DATA_W      (DATA_W),
      .XOR_OUT     (XOR_OUT),
      .REFLECT_OUT (REFLECT_OUT)
   ) i_tail (
      .crc_i (crc_q),
      .sel_i (cnt),
      .nib_o (tail_nib)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_OPEN;
         cnt      <= '0;
         out_vld  <= 1'b0;
         out_dat  <= '0;
         out_last <= 1'b0;
      end else begin
         case (st)
            ST_OPEN: begin
               out_vld  <= accept;
               out_dat  <= in_dat;
               out_last <= 1'b0;
               if (accept && in_eof) begin
                  st  <= ST_TAIL;
                  cnt <= '0;
               end
            end
            ST_TAIL: begin
               out_vld  <= 1'b1;
               out_dat  <= tail_nib;
               out_last <= (cnt == CNT_LAST);
               if (cnt == CNT_LAST) begin
                  st <= ST_OPEN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_OPEN;
         endcase
      end
   end

   // R2: accepted nibble forwarded next cycle
   p_pass_r2: assert property (@(posedge clk) disable iff (rst)
      accept |=> (out_vld && !out_last && out_dat == $past(in_dat)))
      else $error("accepted nibble not forwarded");

   // R6: end of frame stalls the input
   p_eof_stall_r6: assert property (@(posedge clk) disable iff (rst)
      (accept && in_eof) |=> !in_rdy)
      else $error("input not stalled after end of frame");

   // R4: the tail runs without gaps while input is stalled
   p_tail_cont_r4: assert property (@(posedge clk) disable iff (rst)
      !in_rdy |=> out_vld)
      else $error("gap in FCS output");

   // R5: last marks the final tail slice, just as input reopens
   p_last_end_r5: assert property (@(posedge clk) disable iff (rst)
      out_last |-> (out_vld && in_rdy && $past(!in_rdy)))
      else $error("last asserted out of place");

   p_last_once_r5: assert property (@(posedge clk) disable iff (rst)
      out_last |=> !out_last)
      else $error("last held for more than one cycle");

endmodule

// File: tb/test_nib_fcs_gen.sv
module test_nib_fcs_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_vld = 1'b0;
   logic       in_sof = 1'b0;
   logic       in_eof = 1'b0;
   logic [3:0] in_dat = 4'h0;
   logic       in_rdy;
   logic       out_vld;
   logic [3:0] out_dat;
   logic       out_last;

   always #5 clk = ~clk;

   nib_fcs_gen i_nib_fcs_gen (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (in_vld),
      .in_sof   (in_sof),
      .in_eof   (in_eof),
      .in_dat   (in_dat),
      .in_rdy   (in_rdy),
      .out_vld  (out_vld),
      .out_dat  (out_dat),
      .out_last (out_last)
   );

   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 0;
   // entry: [6] fcs slice, [5] valid, [4] last, [3:0] nibble
   logic [6:0]  pend[$];
   logic [31:0] m_crc  = 32'hFFFFFFFF;
   logic [31:0] m_fcs  = 32'h0;
   logic [31:0] cap    = 32'h0;
   logic [31:0] seen_fcs = 32'h0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Bit-serial reflected CRC-32, one bit at a time, LSB first.
   task automatic model_accept(logic s, logic e, logic [3:0] d);
      if (s) m_crc = 32'hFFFFFFFF;
      for (int b = 0; b < 4; b++) begin
         logic fb;
         fb    = m_crc[0] ^ d[b];
         m_crc = m_crc >> 1;
         if (fb) m_crc = m_crc ^ 32'hEDB88320;
      end
      pend.push_back({1'b0, 1'b1, 1'b0, d});
      if (e) begin
         m_fcs = ~m_crc;
         for (int k = 0; k < 8; k++)
            pend.push_back({1'b1, 1'b1, (k == 7), m_fcs[4*k +: 4]});
      end
   endtask

   // Called at a falling edge: compare this cycle's outputs to the model.
   task automatic observe();
      logic [6:0] e;
      string      req;
      e = (pend.size() != 0) ? pend.pop_front() : 7'h0;
      if (!e[5])      req = "R9/R6 idle";
      else if (e[4])  req = "R5/R4 last FCS";
      else if (e[6])  req = "R4/R3 FCS slice";
      else            req = "R2 data";
      if (e[5]) chk(req, {out_vld, out_last, out_dat}, {e[5], e[4], e[3:0]});
      else      chk(req, {out_vld, out_last}, 2'b00);
      if (out_vld) cap = {out_dat, cap[31:4]};
      if (out_last) seen_fcs = cap;
      chk("R6 ready", in_rdy, (pend.size() == 0));
   endtask

   task automatic step(logic v, logic s, logic e, logic [3:0] d, output bit acc);
      @(negedge clk);
      observe();
      if (pend.size() != 0 && v) begin
         // stalled: present junk that must be ignored (R6)
         in_vld = 1'b1;
         in_sof = 1'($urandom);
         in_eof = 1'($urandom);
         in_dat = 4'($urandom);
         acc    = 0;
      end else begin
         in_vld = v; in_sof = s; in_eof = e; in_dat = d;
         acc    = v;
         if (v) model_accept(s, e, d);
      end
   endtask

   task automatic send_nib(logic s, logic e, logic [3:0] d);
      bit acc = 0;
      while (!acc) step(1'b1, s, e, d, acc);
   endtask

   task automatic idle(int n);
      bit acc;
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 4'h0, acc);
   endtask

   task automatic send_bytes(logic [7:0] q[$], int gap_pct);
      for (int i = 0; i < q.size(); i++) begin
         for (int h = 0; h < 2; h++) begin
            if (!(i == 0 && h == 0) && ($urandom % 100) < gap_pct)
               idle(1 + $urandom % 3);                      // R9 gaps
            send_nib((i == 0 && h == 0), (i == q.size()-1 && h == 1),
                     h ? q[i][7:4] : q[i][3:0]);
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      pend.delete();
      repeat (2) @(negedge clk);
      chk("R1 out_vld in reset", out_vld, 0);
      chk("R1 out_last in reset", out_last, 0);
      chk("R1 in_rdy in reset", in_rdy, 1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 out_vld after reset", out_vld, 0);
      chk("R1 in_rdy after reset", in_rdy, 1);
   endtask

   initial begin
      logic [7:0] q[$];
      do_reset();

      // R7: check string
      q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      send_bytes(q, 0);
      idle(10);
      chk("R7 model FCS", m_fcs, 32'hCBF43926);
      chk("R7 observed FCS", seen_fcs, 32'hCBF43926);

      // R8: single-nibble frame, then one-byte frame back to back
      send_nib(1'b1, 1'b1, 4'hA);
      q = '{8'h5C};
      send_bytes(q, 0);
      idle(10);
      chk("R8 one-byte frame FCS", seen_fcs, m_fcs);

      // R1: reset in the middle of an FCS tail
      q = '{8'h11, 8'h22, 8'h33};
      send_bytes(q, 0);
      idle(3);
      do_reset();
      idle(2);

      // R3/R8/R9: random frames, random gaps, back to back
      for (int f = 0; f < 40; f++) begin
         int len;
         len = 1 + $urandom % 120;
         q.delete();
         for (int i = 0; i < len; i++) q.push_back(8'($urandom));
         send_bytes(q, (f % 3 == 0) ? 0 : 25);
         if (f % 4 == 1) idle($urandom % 4);
      end
      idle(12);
      chk("R8 last random frame FCS", seen_fcs, m_fcs);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule